// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog with Gated Management Interrupt

This block is a countdown watchdog of the kind found in a platform controller. Software writes a reload value, clears a halt bit, and then kicks the timer from time to time. Each kick copies the reload value into the counter. The counter moves down by one on every prescaled tick. When a tick arrives while the counter is at zero, the counter reloads and an expiry takes place.

The first expiry only raises a timeout flag. While that flag is set, the block can request a system-management interrupt, provided two enable bits in a 32-bit interrupt control word allow it. A second expiry that finds the flag still set raises a one-cycle system reset request. A no-reboot strap can veto that request. The hang seen before a reset therefore lasts between one and two timeout periods, unless software or firmware clears the flag in between.

All registers sit on a small word-addressed write/read bus. Reads return one cycle after the address is presented.

Top module: `dual_expiry_wdog`

## Requirements
- R1: After the synchronous active-high reset, the registers hold these values:
  - the interrupt control word reads 0x0000_2001;
  - the timer control register reads 0x0000_0800, which means halted;
  - the status register and the reload register read 0;
  - the counter is 0;
  - `smi_o` and `rst_req_o` are low.
- R2: The register map has four word addresses. Reads are registered, and `bus_rdata` shows the addressed register on the cycle after the address is presented.
  - Address 0 is the interrupt control word, and all 32 bits are read/write.
  - Address 1 is the timer control register: bit 11 is the halt bit, and bit 0 is a kick that acts on the write and reads back as 0.
  - Address 2 is the status register: bit 0 is the timeout flag.
  - Address 3 is the reload value, CNT_W bits wide.
- R3: On each `tick_i` cycle while the timer is not halted, the counter decrements. A tick that finds the counter at 0 is an expiry, and the counter reloads on it, so one period is reload+1 ticks.
- R4: While the halt bit is set, ticks neither decrement the counter nor cause an expiry.
- R5: An expiry that finds the timeout flag clear sets the flag and produces no reset request.
- R6: An expiry that finds the timeout flag already set drives `rst_req_o` high for exactly one cycle, on the cycle after the expiring tick. The flag stays set.
- R7: While `no_reboot_i` is high, an expiry that would fire the reset request produces none.
- R8: Writing 1 to status bit 0 clears the timeout flag. If the flag is cleared between two expiries, the next expiry only sets the flag again and produces no reset.
- R9: `smi_o` goes high one cycle after the timeout flag is set, but only when control word bit 13 (watchdog interrupt enable) and bit 0 (global interrupt enable) are both set. It goes low one cycle after any of the three goes low.
- R10: A kick loads the counter from the reload register. When a kick and a tick arrive in the same cycle, the kick wins and no expiry occurs.
- R11: When an expiry and a flag-clear write arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_i | input | 1 | Prescaled count enable, one cycle per tick |
| no_reboot_i | input | 1 | Strap; high vetoes the reset request |
| smi_o | output | 1 | Management interrupt request level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench counts ticks exactly, so a counter that is off by one, or that keeps moving while halted, shows up as an expiry one tick early or late.

Several cases target the two-expiry rule:
- A first expiry must not reset. A design that resets on the first expiry fires `rst_req_o` too early.
- A reset pulse wider than one cycle is counted twice.
- A flag cleared between expiries must prevent the reset.
- The no-reboot strap must veto the reset.

The bench also covers the same-cycle collision of an expiry with a flag clear, where a design with the wrong priority drops the flag. It walks the interrupt level through each enable combination and through software start/stop read-modify-write of the control word, which catches a swapped or missing gate bit and any bit lost on write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam logic [1:0]  A_SMICTL    = 2'd0;
  localparam logic [1:0]  A_TCTL      = 2'd1;
  localparam logic [1:0]  A_STAT      = 2'd2;
  localparam logic [1:0]  A_RELOAD    = 2'd3;
  localparam int unsigned HALT_BIT    = 11;
  localparam int unsigned KICK_BIT    = 0;
  localparam int unsigned WD_SMI_BIT  = 13;
  localparam int unsigned GLB_SMI_BIT = 0;
  localparam int unsigned FLAG_BIT    = 0;
  localparam logic [WORD_W-1:0] SMICTL_RST = 32'h0000_2001;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              flag,
  output logic [WORD_W-1:0] smi_ctl,
  output logic              halt,
  output logic              kick,
  output logic              w1c,
  output logic [CNT_W-1:0]  reload,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned PAD_W = WORD_W - CNT_W;

  logic [WORD_W-1:0] rd_mux;

  assign kick = we && (addr == A_TCTL) && wdata[KICK_BIT];
  assign w1c  = we && (addr == A_STAT) && wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_ctl <= SMICTL_RST;
      halt    <= 1'b1;
      reload  <= '0;
    end else if (we) begin
      case (addr)
        A_SMICTL: smi_ctl <= wdata;
        A_TCTL:   halt    <= wdata[HALT_BIT];
        A_RELOAD: reload  <= wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_SMICTL: rd_mux = smi_ctl;
      A_TCTL:   rd_mux[HALT_BIT] = halt;
      A_STAT:   rd_mux[FLAG_BIT] = flag;
      default:  rd_mux = {{PAD_W{1'b0}}, reload};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic live_tick;

  assign live_tick = tick && !halt && !kick;
  assign expire    = live_tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (kick)      cnt <= reload;
    else if (expire)    cnt <= reload;
    else if (live_tick) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic w1c,
  input  logic no_reboot,
  input  logic wd_smi_en,
  input  logic glb_smi_en,
  output logic flag,
  output logic smi,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      smi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (expire)   flag <= 1'b1;
      else if (w1c) flag <= 1'b0;
      rst_req <= expire && flag && !no_reboot;
      smi     <= flag && wd_smi_en && glb_smi_en;
    end
  end
endmodule

// File: rtl/dual_expiry_wdog.sv
module dual_expiry_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_i,
  input  logic        no_reboot_i,
  output logic        smi_o,
  output logic        rst_req_o
);
  logic [WORD_W-1:0] smi_ctl;
  logic              halt, kick, w1c, expire, flag;
  logic [CNT_W-1:0]  reload, cnt;

  wdog_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .flag(flag), .smi_ctl(smi_ctl), .halt(halt), .kick(kick), .w1c(w1c),
    .reload(reload), .rdata(bus_rdata)
  );

  wdog_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick_i), .halt(halt), .kick(kick),
    .reload(reload), .cnt(cnt), .expire(expire)
  );

  wdog_status stat_i (
    .clk(clk), .rst(rst), .expire(expire), .w1c(w1c), .no_reboot(no_reboot_i),
    .wd_smi_en(smi_ctl[WD_SMI_BIT]), .glb_smi_en(smi_ctl[GLB_SMI_BIT]),
    .flag(flag), .smi(smi_o), .rst_req(rst_req_o)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             halt,
  input logic             kick,
  input logic             expire,
  input logic             w1c,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      smi_ctl,
  input logic             no_reboot,
  input logic             smi,
  input logic             rst_req
);
  // R4: a halted counter without a kick holds its value
  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (halt && !kick) |=> $stable(cnt));

  // R5: every expiry leaves the flag set
  p_expiry_sets_r5: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);

  // R6: a reset request needs a prior set flag and an expiry
  p_rst_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(flag) && $past(expire)));

  // R7: the strap vetoes the reset request
  p_no_reboot_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(no_reboot));

  // R8: the flag only falls through a clear write
  p_w1c_only_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag) && !$past(rst)) |-> $past(w1c));

  // R9: the interrupt needs both enables and the flag
  p_smi_gate_r9: assert property (@(posedge clk) disable iff (rst)
    smi |-> ($past(smi_ctl[13]) && $past(smi_ctl[0]) && $past(flag)));
endmodule

bind dual_expiry_wdog wdog_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .halt(halt), .kick(kick), .expire(expire),
  .w1c(w1c), .flag(flag), .cnt(cnt), .smi_ctl(smi_ctl),
  .no_reboot(no_reboot_i), .smi(smi_o), .rst_req(rst_req_o)
);

// File: tb/dual_expiry_wdog_tb_top.sv
module dual_expiry_wdog_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_i = 1'b0;
  logic        no_reboot_i = 1'b0;
  logic        smi_o, rst_req_o;

  int n_checks = 0;
  int n_errs   = 0;
  int rst_pulses = 0;
  bit done = 1'b0;

  typedef struct { string req; logic [31:0] exp; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_expiry_wdog #(.CNT_W(10)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i),
    .no_reboot_i(no_reboot_i), .smi_o(smi_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after the address
  always @(posedge clk) rd_seen <= rd_req;
  always @(negedge clk) begin
    if (!rst && rst_req_o) rst_pulses++;
    if (rd_seen && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.req, bus_rdata, it.exp);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_exp(logic [1:0] a, logic [31:0] e, string req);
    sb_item_t it;
    it.req = req; it.exp = e;
    @(negedge clk); bus_addr = a; sb_q.push_back(it); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 smi", {31'b0, smi_o}, 32'd0);
    chk("R1 rst_req", {31'b0, rst_req_o}, 32'd0);
    rd_exp(2'd0, 32'h0000_2001, "R1 ctl word");
    rd_exp(2'd1, 32'h0000_0800, "R1 halted");
    rd_exp(2'd2, 32'd0, "R1 flag");
    rd_exp(2'd3, 32'd0, "R1 reload");

    // R4 halted at zero: no expiry
    ticks(10);
    rd_exp(2'd2, 32'd0, "R4 halted no expiry");

    // R2/R3/R5 first expiry after reload+1 ticks
    wr(2'd3, 32'hFFFF_FC03);          // only 10 bits kept -> 3
    rd_exp(2'd3, 32'd3, "R2 reload width");
    wr(2'd1, 32'h0000_0001);          // kick, unhalt
    rd_exp(2'd1, 32'd0, "R2 kick reads 0");
    ticks(3);
    rd_exp(2'd2, 32'd0, "R3 no early expiry");
    ticks(1);
    rd_exp(2'd2, 32'd1, "R5 flag set");
    chk("R5 no reset", rst_pulses, 0);
    chk("R9 smi high", {31'b0, smi_o}, 32'd1);

    // R6 second expiry -> exactly one reset cycle
    ticks(3);
    chk("R6 not yet", rst_pulses, 0);
    ticks(1);
    idle(2);
    chk("R6 single pulse", rst_pulses, 1);
    rd_exp(2'd2, 32'd1, "R6 flag kept");

    // R8 clear between expiries prevents reset
    wr(2'd2, 32'd1);
    rd_exp(2'd2, 32'd0, "R8 flag cleared");
    chk("R9 smi low", {31'b0, smi_o}, 32'd0);
    ticks(4);
    rd_exp(2'd2, 32'd1, "R8 flag set again");
    chk("R8 no reset", rst_pulses, 1);

    // R4 halt mid-count, then resume
    wr(2'd1, 32'h0000_0801);
    ticks(6);
    chk("R4 halted no reset", rst_pulses, 1);
    wr(2'd1, 32'h0000_0000);
    ticks(3);
    chk("R4 resume exact count", rst_pulses, 1);
    ticks(1);
    idle(1);
    chk("R6 reset after resume", rst_pulses, 2);

    // R7 strap veto
    no_reboot_i = 1'b1;
    ticks(4);
    idle(1);
    chk("R7 vetoed", rst_pulses, 2);
    rd_exp(2'd2, 32'd1, "R7 flag still set");
    no_reboot_i = 1'b0;

    // R10 keepalive
    wr(2'd2, 32'd1);
    wr(2'd1, 32'd1);
    for (int k = 0; k < 3; k++) begin
      ticks(3);
      wr(2'd1, 32'd1);
    end
    rd_exp(2'd2, 32'd0, "R10 kicks prevent expiry");
    ticks(3);
    @(negedge clk); tick_i = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'd1;
    @(negedge clk); tick_i = 1'b0; bus_we = 1'b0;
    rd_exp(2'd2, 32'd0, "R10 kick beats tick");
    ticks(4);
    rd_exp(2'd2, 32'd1, "R3 full period after kick");

    // R11 expiry vs clear same cycle
    wr(2'd2, 32'd1);
    wr(2'd1, 32'd1);
    ticks(3);
    @(negedge clk); tick_i = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 32'd1;
    @(negedge clk); tick_i = 1'b0; bus_we = 1'b0;
    rd_exp(2'd2, 32'd1, "R11 set wins");
    chk("R11 no reset", rst_pulses, 2);

    // R9 gating, R2 control word storage with start/stop RMW
    wr(2'd0, 32'h0000_0001);
    idle(1);
    chk("R9 wd enable off", {31'b0, smi_o}, 32'd0);
    wr(2'd0, 32'h0000_2000);
    idle(1);
    chk("R9 global off", {31'b0, smi_o}, 32'd0);
    wr(2'd0, 32'hFFFF_FFFF);
    idle(1);
    chk("R9 both on", {31'b0, smi_o}, 32'd1);
    wr(2'd0, 32'hFFFF_FFFF & ~32'h0000_2001);
    rd_exp(2'd0, 32'hFFFF_DFFE, "R2 start RMW kept bits");
    chk("R9 start gates smi", {31'b0, smi_o}, 32'd0);
    wr(2'd0, 32'hFFFF_DFFE | 32'h0000_2001);
    rd_exp(2'd0, 32'hFFFF_FFFF, "R2 stop RMW kept bits");
    chk("R9 stop restores smi", {31'b0, smi_o}, 32'd1);
    wr(2'd0, 32'h5A5A_A5A5);
    rd_exp(2'd0, 32'h5A5A_A5A5, "R2 ctl word pattern");

    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule